// File: doc/BRIEF.md
# DMA Channel Register File

This block is the host-side programming interface of a four-channel DMA engine. A host reaches it through a byte-wide port bus with a 4-bit port index. The lower eight ports expose the 16-bit address and count registers of each channel. Each 16-bit register is reached one byte at a time, and a single byte pointer shared by all channels selects which byte. The upper eight ports carry the controller functions: command, software request, single-channel mask, channel mode, pointer clear, soft reset, clear-all-mask and load-all-mask. A channel scheduler outside the block consumes the mask, request, mode and command state from registered outputs.

The scheduler reports progress back over a small advance interface. Each pulse adds one to the selected channel's current count and can also raise that channel's terminal-count flag. When the host reads the address or count of a channel, it receives live values derived from the base register, the current address and the current count. It does not receive the stored base value. All bus actions are sampled on one clock, and read data appears one cycle after the read strobe.

Top module: `dma_regfile`

## Requirements
- R1: A synchronous active-high reset leaves the mask at all ones (the mask port reads 0x0F), and clears the request, terminal-count, command, byte pointer and read data.
- R2: On ports 0 to 7, the channel is addr[2:1], and addr[0] selects the address register (0) or the count register (1). Every read or write to these ports toggles one byte pointer shared by all channels. When the pointer is 0, the access uses the low byte; when it is 1, the access uses the high byte.
- R3: A high-byte write reloads that channel. Its current address becomes the base address shifted left by WORD_SHIFT, and its current count becomes 0.
- R4: An address read returns the current address plus the current count, or minus the current count when mode bit 5 is set. A count read returns the base count shifted left by WORD_SHIFT, minus the current count. The byte is chosen by the pointer and appears on rdata in the cycle after rd_en.
- R5: A write to port 8 loads the command only if the value is 0x00 or 0x04. Any other value is ignored.
- R6: A write to port 9 selects the channel with data[1:0]. Data bit 2 sets or clears that channel's request, and the channel's terminal-count flag is always cleared. The status byte holds the terminal-count flags in bits 3:0 and the request flags in bits 7:4.
- R7: A write to port 0xA sets or clears the mask of channel data[1:0] according to data bit 2. A write to port 0xE clears every mask bit. A write to port 0xF loads the mask from data[3:0].
- R8: A write to port 0xB stores the whole byte as the mode of channel data[1:0]. Channel n's mode appears on mode_o[8n+7:8n].
- R9: A write to port 0xC clears the byte pointer. A write to port 0xD clears the pointer, command, requests and terminal-count flags and sets all mask bits. Channel registers and modes keep their values.
- R10: A read of port 8 returns the status byte and then clears the terminal-count flags. A read of port 0xF returns the mask. Reads of ports 9 to 0xE return 0.
- R11: A sched_adv pulse adds 1 to the current count of channel sched_ch. If sched_tc is also high, the pulse sets that channel's terminal-count flag. This set takes priority over a status-read clear, a port-9 clear or a soft reset in the same cycle.
- R12: When a reload and an advance hit the same channel in the same cycle, the reload takes priority and the count becomes 0.
- R13: When wr_en and rd_en are both high, only the write takes effect, and rdata keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Port index |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| sched_adv | input | 1 | Scheduler advance pulse |
| sched_ch | input | 2 | Channel that advances |
| sched_tc | input | 1 | Terminal count reached with this advance |
| mask_o | output | 4 | Channel mask bits |
| req_o | output | 4 | Software request bits |
| mode_o | output | 32 | Mode byte of every channel |
| cmd_o | output | 8 | Command register |

## Verification
Two events can land in the same clock cycle. A terminal-count set from the scheduler can coincide with a host action that clears the same flag: a status read or a port-9 write. A channel reload from a high-byte write can likewise coincide with an advance pulse for the same channel. The bench provokes each pair by raising sched_adv and sched_tc during the bus strobe. It then judges the outcome through later reads: a status read must still show the flag, and the count readback must equal the full base count.

// File: rtl/dma_regfile_pkg.sv
package dma_regfile_pkg;

  localparam int PORT_W = 4;

  typedef enum logic [PORT_W-1:0] {
    PORT_CMD      = 4'h8,
    PORT_SWREQ    = 4'h9,
    PORT_MASK_ONE = 4'hA,
    PORT_MODE     = 4'hB,
    PORT_PTR_CLR  = 4'hC,
    PORT_SOFT_RST = 4'hD,
    PORT_MASK_CLR = 4'hE,
    PORT_MASK_ALL = 4'hF
  } ctl_port_e;

  localparam int MODE_DEC_BIT = 5;
  localparam int FLAG_BIT     = 2;
  localparam logic [7:0] CMD_KEEP_BITS = 8'h04;

  function automatic logic cmd_ok(input logic [7:0] v);
    return (v == 8'h00) || ((v & ~CMD_KEEP_BITS) == 8'h00);
  endfunction

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regfile_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int WORD_SHIFT = 0,
  localparam int BASE_W    = 2 * DATA_W,
  localparam int CUR_W     = BASE_W + WORD_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic              sel_cnt_i,
  input  logic              hi_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              mode_we_i,
  input  logic              adv_i,
  output logic [DATA_W-1:0] mode_o,
  output logic [CUR_W-1:0]  addr_rb_o,
  output logic [CUR_W-1:0]  cnt_rb_o
);

  logic [BASE_W-1:0] base_addr_q, base_addr_d;
  logic [BASE_W-1:0] base_cnt_q, base_cnt_d;
  logic [CUR_W-1:0]  cur_addr_q, cur_cnt_q;
  logic [DATA_W-1:0] mode_q;
  logic              reload;

  assign reload = wr_i & hi_i;

  always_comb begin
    base_addr_d = base_addr_q;
    base_cnt_d  = base_cnt_q;
    if (wr_i) begin
      if (sel_cnt_i) begin
        if (hi_i) base_cnt_d[BASE_W-1:DATA_W] = wdata_i;
        else      base_cnt_d[DATA_W-1:0]      = wdata_i;
      end else begin
        if (hi_i) base_addr_d[BASE_W-1:DATA_W] = wdata_i;
        else      base_addr_d[DATA_W-1:0]      = wdata_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      cur_addr_q  <= '0;
      cur_cnt_q   <= '0;
      mode_q      <= '0;
    end else begin
      base_addr_q <= base_addr_d;
      base_cnt_q  <= base_cnt_d;
      if (reload) begin
        cur_addr_q <= CUR_W'(base_addr_d) << WORD_SHIFT;
        cur_cnt_q  <= '0;
      end else if (adv_i) begin
        cur_cnt_q <= cur_cnt_q + CUR_W'(1);
      end
      if (mode_we_i) mode_q <= wdata_i;
    end
  end

  assign mode_o    = mode_q;
  assign addr_rb_o = mode_q[MODE_DEC_BIT] ? (cur_addr_q - cur_cnt_q)
                                          : (cur_addr_q + cur_cnt_q);
  assign cnt_rb_o  = (CUR_W'(base_cnt_q) << WORD_SHIFT) - cur_cnt_q;

  assert_reload_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_i && hi_i) |=> (cur_addr_q == (CUR_W'(base_addr_q) << WORD_SHIFT)));

  assert_adv_step_R11: assert property (@(posedge clk) disable iff (rst)
    (adv_i && !(wr_i && hi_i)) |=> (cur_cnt_q == $past(cur_cnt_q) + CUR_W'(1)));

  assert_reload_wins_R12: assert property (@(posedge clk) disable iff (rst)
    (wr_i && hi_i && adv_i) |=> (cur_cnt_q == '0));

endmodule

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
  import dma_regfile_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              adv_i,
  input  logic [CH_W-1:0]   adv_ch_i,
  input  logic              adv_tc_i,
  output logic              ff_o,
  output logic [NUM_CH-1:0] mask_o,
  output logic [NUM_CH-1:0] req_o,
  output logic [NUM_CH-1:0] tc_o,
  output logic [DATA_W-1:0] cmd_o
);

  logic              ff_q, ff_d;
  logic [NUM_CH-1:0] mask_q, mask_d, req_q, req_d, tc_q, tc_d;
  logic [DATA_W-1:0] cmd_q, cmd_d;
  logic [CH_W-1:0]   wch;

  assign wch = wdata_i[CH_W-1:0];

  always_comb begin
    ff_d   = ff_q;
    mask_d = mask_q;
    req_d  = req_q;
    tc_d   = tc_q;
    cmd_d  = cmd_q;
    if ((wr_i || rd_i) && !port_i[PORT_W-1]) ff_d = ~ff_q;
    if (wr_i) begin
      case (port_i)
        PORT_CMD:      if (cmd_ok(wdata_i)) cmd_d = wdata_i;
        PORT_SWREQ: begin
          req_d[wch] = wdata_i[FLAG_BIT];
          tc_d[wch]  = 1'b0;
        end
        PORT_MASK_ONE: mask_d[wch] = wdata_i[FLAG_BIT];
        PORT_PTR_CLR:  ff_d = 1'b0;
        PORT_SOFT_RST: begin
          ff_d   = 1'b0;
          mask_d = '1;
          req_d  = '0;
          tc_d   = '0;
          cmd_d  = '0;
        end
        PORT_MASK_CLR: mask_d = '0;
        PORT_MASK_ALL: mask_d = wdata_i[NUM_CH-1:0];
        default: ;
      endcase
    end
    if (rd_i && (port_i == PORT_CMD)) tc_d = '0;
    if (adv_i && adv_tc_i) tc_d[adv_ch_i] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ff_q   <= 1'b0;
      mask_q <= '1;
      req_q  <= '0;
      tc_q   <= '0;
      cmd_q  <= '0;
    end else begin
      ff_q   <= ff_d;
      mask_q <= mask_d;
      req_q  <= req_d;
      tc_q   <= tc_d;
      cmd_q  <= cmd_d;
    end
  end

  assign ff_o   = ff_q;
  assign mask_o = mask_q;
  assign req_o  = req_q;
  assign tc_o   = tc_q;
  assign cmd_o  = cmd_q;

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask_q == '1 && cmd_q == '0 && req_q == '0 && tc_q == '0 && !ff_q));

  assert_cmd_reject_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_i && port_i == PORT_CMD && !cmd_ok(wdata_i)) |=> $stable(cmd_q));

  assert_swreq_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_i && port_i == PORT_SWREQ) |=> (req_q[$past(wch)] == $past(wdata_i[FLAG_BIT])));

  assert_mask_one_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_i && port_i == PORT_MASK_ONE) |=> (mask_q[$past(wch)] == $past(wdata_i[FLAG_BIT])));

  assert_soft_rst_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_i && port_i == PORT_SOFT_RST) |=> (mask_q == '1 && cmd_q == '0 && req_q == '0 && !ff_q));

  assert_stat_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_i && port_i == PORT_CMD && !(adv_i && adv_tc_i)) |=> (tc_q == '0));

  assert_tc_wins_R11: assert property (@(posedge clk) disable iff (rst)
    (adv_i && adv_tc_i) |=> tc_q[$past(adv_ch_i)]);

endmodule

// File: rtl/dma_rd_mux.sv
module dma_rd_mux
  import dma_regfile_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int DATA_W     = 8,
  parameter int WORD_SHIFT = 0,
  localparam int CH_W      = $clog2(NUM_CH),
  localparam int CUR_W     = 2 * DATA_W + WORD_SHIFT
) (
  input  logic [PORT_W-1:0] port_i,
  input  logic              ff_i,
  input  logic [CUR_W-1:0]  addr_rb_i [NUM_CH],
  input  logic [CUR_W-1:0]  cnt_rb_i  [NUM_CH],
  input  logic [NUM_CH-1:0] mask_i,
  input  logic [NUM_CH-1:0] req_i,
  input  logic [NUM_CH-1:0] tc_i,
  output logic [DATA_W-1:0] byte_o
);

  logic [CH_W-1:0]  ch;
  logic [CUR_W-1:0] val, shifted;

  assign ch      = port_i[CH_W:1];
  assign val     = port_i[0] ? cnt_rb_i[ch] : addr_rb_i[ch];
  assign shifted = val >> WORD_SHIFT;

  always_comb begin
    if (!port_i[PORT_W-1]) begin
      byte_o = ff_i ? shifted[2*DATA_W-1:DATA_W] : shifted[DATA_W-1:0];
    end else begin
      case (port_i)
        PORT_CMD:      byte_o = DATA_W'({req_i, tc_i});
        PORT_MASK_ALL: byte_o = DATA_W'(mask_i);
        default:       byte_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
  import dma_regfile_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int DATA_W     = 8,
  parameter int WORD_SHIFT = 0,
  localparam int CH_W      = $clog2(NUM_CH),
  localparam int CUR_W     = 2 * DATA_W + WORD_SHIFT
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [PORT_W-1:0]        addr,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rdata,
  input  logic                     sched_adv,
  input  logic [CH_W-1:0]          sched_ch,
  input  logic                     sched_tc,
  output logic [NUM_CH-1:0]        mask_o,
  output logic [NUM_CH-1:0]        req_o,
  output logic [NUM_CH*DATA_W-1:0] mode_o,
  output logic [DATA_W-1:0]        cmd_o
);

  logic              rd_go;
  logic              ff;
  logic [NUM_CH-1:0] tc;
  logic [CUR_W-1:0]  addr_rb [NUM_CH];
  logic [CUR_W-1:0]  cnt_rb  [NUM_CH];
  logic [DATA_W-1:0] rd_byte;

  assign rd_go = rd_en & ~wr_en;

  dma_ctl_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rst(rst), .wr_i(wr_en), .rd_i(rd_go), .port_i(addr),
    .wdata_i(wdata), .adv_i(sched_adv), .adv_ch_i(sched_ch), .adv_tc_i(sched_tc),
    .ff_o(ff), .mask_o(mask_o), .req_o(req_o), .tc_o(tc), .cmd_o(cmd_o)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic ch_wr, ch_mode_we, ch_adv;
    assign ch_wr      = wr_en && !addr[PORT_W-1] && (addr[CH_W:1] == CH_W'(g));
    assign ch_mode_we = wr_en && (addr == PORT_MODE) && (wdata[CH_W-1:0] == CH_W'(g));
    assign ch_adv     = sched_adv && (sched_ch == CH_W'(g));

    dma_chan_regs #(.DATA_W(DATA_W), .WORD_SHIFT(WORD_SHIFT)) u_chan (
      .clk(clk), .rst(rst), .wr_i(ch_wr), .sel_cnt_i(addr[0]), .hi_i(ff),
      .wdata_i(wdata), .mode_we_i(ch_mode_we), .adv_i(ch_adv),
      .mode_o(mode_o[g*DATA_W +: DATA_W]),
      .addr_rb_o(addr_rb[g]), .cnt_rb_o(cnt_rb[g])
    );
  end

  dma_rd_mux #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .WORD_SHIFT(WORD_SHIFT)) u_rd (
    .port_i(addr), .ff_i(ff), .addr_rb_i(addr_rb), .cnt_rb_i(cnt_rb),
    .mask_i(mask_o), .req_i(req_o), .tc_i(tc), .byte_o(rd_byte)
  );

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_go) rdata <= rd_byte;
  end

  assert_wr_over_rd_R13: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_en) |=> $stable(rdata));

  assert_mask_readback_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && addr == PORT_MASK_ALL) |=> (rdata == DATA_W'($past(mask_o))));

endmodule

// File: tb/test_dma_regfile.sv
module test_dma_regfile;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       sched_adv = 1'b0, sched_tc = 1'b0;
  logic [1:0] sched_ch = '0;
  logic [3:0] mask_o, req_o;
  logic [31:0] mode_o;
  logic [7:0] cmd_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic rd_d = 1'b0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  dma_regfile i_dma_regfile (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .sched_adv(sched_adv), .sched_ch(sched_ch),
    .sched_tc(sched_tc), .mask_o(mask_o), .req_o(req_o), .mode_o(mode_o),
    .cmd_o(cmd_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: compare registered read data against scoreboard
  always @(posedge clk) rd_d <= rd_en & ~wr_en & ~rst;
  always @(negedge clk) begin
    if (rd_d) begin
      if (exp_q.size() == 0) chk("R4 unexpected read", 32'h1, 32'h0);
      else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic op(input logic w, input logic r, input logic [3:0] a, input logic [7:0] d,
                    input logic adv, input logic [1:0] ach, input logic atc,
                    input logic [7:0] exp, input string tag);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d;
    sched_adv = adv; sched_ch = ach; sched_tc = atc;
    if (r && !w) begin
      exp_q.push_back(exp);
      tag_q.push_back(tag);
    end
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; sched_adv = 1'b0; sched_tc = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    op(1'b1, 1'b0, a, d, 1'b0, 2'd0, 1'b0, 8'h00, "");
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
    op(1'b0, 1'b1, a, 8'h00, 1'b0, 2'd0, 1'b0, exp, tag);
  endtask

  task automatic adv(input logic [1:0] ch, input logic tc);
    op(1'b0, 1'b0, 4'h0, 8'h00, 1'b1, ch, tc, 8'h00, "");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 mask_o", mask_o, 4'hF);
    chk("R1 req_o", req_o, 4'h0);
    chk("R1 cmd_o", cmd_o, 8'h00);
    chk("R1 rdata", rdata, 8'h00);
    rd(4'hF, 8'h0F, "R1 mask read");
    rd(4'h8, 8'h00, "R1 status read");

    // R2/R3 program channel 1
    wr(4'h2, 8'h34); wr(4'h2, 8'h12);
    wr(4'h3, 8'hFF); wr(4'h3, 8'h00);
    rd(4'h2, 8'h34, "R2 ch1 addr lo");
    rd(4'h2, 8'h12, "R3 ch1 addr hi");
    rd(4'h3, 8'hFF, "R3 ch1 count lo");
    rd(4'h3, 8'h00, "R2 ch1 count hi");

    // R4/R11 advances, increment then decrement readback
    adv(2'd1, 1'b0); adv(2'd1, 1'b0); adv(2'd1, 1'b0);
    rd(4'h2, 8'h37, "R4 ch1 addr inc lo");
    rd(4'h2, 8'h12, "R4 ch1 addr inc hi");
    rd(4'h3, 8'hFC, "R11 ch1 count lo");
    rd(4'h3, 8'h00, "R4 ch1 count hi");
    wr(4'hB, 8'h21);
    chk("R8 mode ch1", mode_o[15:8], 8'h21);
    chk("R8 mode ch0 untouched", mode_o[7:0], 8'h00);
    rd(4'h2, 8'h31, "R4 ch1 addr dec lo");
    rd(4'h2, 8'h12, "R4 ch1 addr dec hi");

    // R2 shared pointer, R9 pointer clear
    wr(4'h0, 8'hAA);
    rd(4'h3, 8'h00, "R2 shared pointer hi byte");
    wr(4'h0, 8'hBB);
    wr(4'hC, 8'h00);
    rd(4'h2, 8'h31, "R9 pointer clear gives lo");
    wr(4'hC, 8'h00);

    // R5 command filter
    wr(4'h8, 8'h04); chk("R5 cmd accept 04", cmd_o, 8'h04);
    wr(4'h8, 8'h01); chk("R5 cmd reject 01", cmd_o, 8'h04);
    wr(4'h8, 8'h00); chk("R5 cmd accept 00", cmd_o, 8'h00);
    wr(4'h8, 8'h84); chk("R5 cmd reject 84", cmd_o, 8'h00);

    // R6 software request
    wr(4'h9, 8'h06); chk("R6 req set ch2", req_o, 4'h4);
    rd(4'h8, 8'h40, "R6 status req bit");
    wr(4'h9, 8'h02); chk("R6 req clear ch2", req_o, 4'h0);

    // R10 terminal count read clear, R6 port 9 clears tc
    adv(2'd0, 1'b1); adv(2'd3, 1'b1);
    rd(4'h8, 8'h09, "R10 status tc bits");
    rd(4'h8, 8'h00, "R10 status cleared");
    adv(2'd2, 1'b1);
    wr(4'h9, 8'h06);
    rd(4'h8, 8'h40, "R6 port9 clears tc");
    wr(4'h9, 8'h02);

    // R7 masks
    wr(4'hE, 8'h00); chk("R7 mask clear all", mask_o, 4'h0);
    wr(4'hA, 8'h05); chk("R7 mask set ch1", mask_o, 4'h2);
    wr(4'hA, 8'h01); chk("R7 mask clear ch1", mask_o, 4'h0);
    wr(4'hF, 8'h0A); chk("R7 mask load", mask_o, 4'hA);
    rd(4'hF, 8'h0A, "R7 mask read");
    wr(4'hF, 8'hFF); chk("R7 mask load all", mask_o, 4'hF);

    // R9 soft reset
    wr(4'h8, 8'h04); wr(4'h9, 8'h04); wr(4'h0, 8'hCC);
    wr(4'hE, 8'h00);
    wr(4'hD, 8'h00);
    chk("R9 mask set", mask_o, 4'hF);
    chk("R9 cmd clear", cmd_o, 8'h00);
    chk("R9 req clear", req_o, 4'h0);
    chk("R9 mode kept", mode_o[15:8], 8'h21);
    rd(4'h2, 8'h31, "R9 pointer cleared");
    wr(4'hC, 8'h00);
    rd(4'h8, 8'h00, "R9 status cleared");

    // R10 other control reads return zero
    rd(4'h9, 8'h00, "R10 port 9 read");
    rd(4'hA, 8'h00, "R10 port A read");
    rd(4'hB, 8'h00, "R10 port B read");
    rd(4'hE, 8'h00, "R10 port E read");

    // R11 set wins over same-cycle clears
    op(1'b0, 1'b1, 4'h8, 8'h00, 1'b1, 2'd3, 1'b1, 8'h00, "R11 status read pre-value");
    rd(4'h8, 8'h08, "R11 tc survives read clear");
    rd(4'h8, 8'h00, "R10 tc cleared after read");
    op(1'b1, 1'b0, 4'h9, 8'h03, 1'b1, 2'd3, 1'b1, 8'h00, "");
    rd(4'h8, 8'h08, "R11 tc survives port9 clear");

    // R12 reload beats same-cycle advance
    wr(4'h2, 8'h00);
    op(1'b1, 1'b0, 4'h2, 8'h20, 1'b1, 2'd1, 1'b0, 8'h00, "");
    rd(4'h3, 8'hFF, "R12 count lo after reload");
    rd(4'h3, 8'h00, "R12 count hi after reload");
    rd(4'h2, 8'h00, "R3 new addr lo");
    rd(4'h2, 8'h20, "R3 new addr hi");
    adv(2'd1, 1'b0);
    rd(4'h2, 8'hFF, "R4 dec wrap lo");
    rd(4'h2, 8'h1F, "R4 dec wrap hi");

    // R13 write wins over read
    op(1'b1, 1'b1, 4'hF, 8'h03, 1'b0, 2'd0, 1'b0, 8'h00, "");
    chk("R13 write applied", mask_o, 4'h3);
    chk("R13 rdata held", rdata, 8'h1F);

    repeat (2) @(negedge clk);
    chk("R4 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule